// File: doc/BRIEF.md
# Pseudo-DMA 16-bit Data Port

This block is the host-facing end of a byte-wide transfer path. A host issues one-byte or two-byte accesses on a 16-bit data port. A write splits the halfword into bytes and pushes them, most significant byte first, into a 16-entry data FIFO. While a command phase is active, the bytes go instead into a separate 32-entry command FIFO. A read pops bytes from the data FIFO and builds the halfword, again with the most significant byte first. Each byte that a write carries uses up one count of a 24-bit transfer counter.

A request line tells the host when it may go on transferring. Loading the counter raises the line. It falls at the end of a write that leaves the counter at zero or the target FIFO full. It also falls at the end of a read that leaves the data FIFO empty. Each of these stops also gives a one-cycle done pulse.

A push into a full FIFO is dropped and gives an overrun pulse. A pop from an empty FIFO returns zero and gives an underrun pulse. The device side reaches the data FIFO through one push stream and one pop stream, and drains the command FIFO through a third pop stream.

The host access stream is valid/ready. `acc_ready` is low in the cycle that handles the second byte of a two-byte access, and it stays low while a read response waits. The read response is held stable until `rsp_ready` takes it. The device streams are back-pressured by FIFO state, and they also pause in any cycle in which the host is moving a byte.

Top module: `pdma_port`

## Requirements
- R1: After reset, `drq`, `rsp_valid`, `done`, `overrun` and `underrun` are 0, `tc_count` is 0, `acc_ready` is 1, and both FIFOs are empty.
- R2: A write with `acc_wide`=1 pushes `acc_wdata[15:8]` in its accept cycle and `acc_wdata[7:0]` in the next cycle, and `acc_ready` is 0 during that second cycle. A write with `acc_wide`=0 pushes only `acc_wdata[7:0]`.
- R3: A read with `acc_wide`=1 puts the first byte it pops in `rsp_data[15:8]` and the second in `rsp_data[7:0]`. A read with `acc_wide`=0 returns `{8'h00, byte}`. `rsp_valid` rises after the last byte cycle and holds with stable data until `rsp_ready`, and `acc_ready` is 0 while `rsp_valid` is 1.
- R4: Each written byte that meets a nonzero `tc_count` lowers the count by one, and this happens even when the push overruns. A written byte that meets a zero count is dropped: nothing is pushed and no flag is raised.
- R5: While `cmd_phase` is 1, written bytes enter the command FIFO, which holds 32 bytes, and the data FIFO is left untouched.
- R6: A push into a full FIFO (16 data bytes or 32 command bytes) is discarded. `overrun` pulses for one cycle and the stored contents and their order do not change.
- R7: A pop from an empty data FIFO yields byte 0x00, pulses `underrun` for one cycle and leaves the FIFO state unchanged.
- R8: A `tc_load` pulse sets `tc_count` to `tc_load_val` and sets `drq` to 1 on the next edge. A load takes precedence over a stop in the same cycle.
- R9: At the end of a write access, if `tc_count` is zero or the target FIFO is full, `drq` goes to 0 and `done` pulses once. Otherwise `drq` keeps its value and `done` stays 0.
- R10: At the end of a read access, if the data FIFO is empty, `drq` goes to 0 and `done` pulses once. Otherwise `drq` keeps its value.
- R11: Both FIFOs are first-in first-out. `dev_wr_ready` means the data FIFO is not full and no host byte is being handled. `dev_rd_valid` means the data FIFO is not empty and no host byte is being handled. `cmd_rd_valid` means the command FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Host access accepted when high together with acc_valid |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_wide | input | 1 | 1 for two-byte access, 0 for one byte |
| acc_wdata | input | 16 | Write halfword |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 16 | Read halfword |
| cmd_phase | input | 1 | Steers writes into the command FIFO |
| tc_load | input | 1 | Load transfer counter and raise drq |
| tc_load_val | input | 24 | Counter load value |
| tc_count | output | 24 | Current transfer count |
| drq | output | 1 | Transfer may continue |
| done | output | 1 | One-cycle pulse when a transfer stops |
| overrun | output | 1 | One-cycle pulse for a discarded push |
| underrun | output | 1 | One-cycle pulse for a pop from empty |
| dev_wr_valid | input | 1 | Device byte into data FIFO |
| dev_wr_ready | output | 1 | Data FIFO accepts a device byte |
| dev_wr_data | input | 8 | Device byte value |
| dev_rd_valid | output | 1 | Data FIFO byte available to device |
| dev_rd_ready | input | 1 | Device takes the data FIFO byte |
| dev_rd_data | output | 8 | Data FIFO head byte |
| cmd_rd_valid | output | 1 | Command FIFO byte available |
| cmd_rd_ready | input | 1 | Device takes the command byte |
| cmd_rd_data | output | 8 | Command FIFO head byte |

## Verification
A FIFO pointer or occupancy count that goes wrong shows up at the device pop ports within a few cycles of draining: bytes come out reordered, duplicated or missing, or `dev_rd_valid` rises or falls at the wrong depth. A counter fault shows on `tc_count` right after the byte edge that caused it. It also shows as `drq` falling one access too early or too late. A fault in the byte sequencer shows on the next read response as swapped halves, or as `acc_ready` coming back a cycle early.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned DEF_DATA_DEPTH = 16;
  localparam int unsigned DEF_CMD_DEPTH  = 32;
  localparam int unsigned DEF_TC_W       = 24;
endpackage

// File: rtl/pdma_byte_fifo.sv
module pdma_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  pdma_pkg::byte_t      push_data,
  input  logic                 pop,
  output pdma_pkg::byte_t      pop_data,
  output logic [CW-1:0]        count,
  output logic [CW-1:0]        count_next
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  pdma_pkg::byte_t mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic push_ok, pop_ok;

  assign push_ok = push && (count != FULLV);
  assign pop_ok  = pop && (count != '0);
  assign pop_data = (count != '0) ? mem[rptr] : 8'h00;

  always_comb begin
    count_next = count;
    if (push_ok && !pop_ok) count_next = count + 1'b1;
    else if (pop_ok && !push_ok) count_next = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      count <= count_next;
      if (push_ok) wptr <= (wptr == LASTP) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LASTP) ? '0 : rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == FULLV && !pop) |=> (count == FULLV));
  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !push) |=> (count == '0));
  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLV);
endmodule

// File: rtl/pdma_tc_counter.sv
module pdma_tc_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_req,
  output logic [W-1:0] count,
  output logic         zero,
  output logic         next_zero
);
  logic [W-1:0] nxt;

  assign zero = (count == '0);

  always_comb begin
    nxt = count;
    if (load) nxt = load_val;
    else if (dec_req && !zero) nxt = count - 1'b1;
  end

  assign next_zero = (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  // R4
  dec_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && zero && !load) |=> (count == '0));
endmodule

// File: rtl/pdma_port.sv
module pdma_port #(
  parameter int unsigned DATA_DEPTH = pdma_pkg::DEF_DATA_DEPTH,
  parameter int unsigned CMD_DEPTH  = pdma_pkg::DEF_CMD_DEPTH,
  parameter int unsigned TC_W       = pdma_pkg::DEF_TC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic            acc_write,
  input  logic            acc_wide,
  input  logic [15:0]     acc_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [15:0]     rsp_data,
  input  logic            cmd_phase,
  input  logic            tc_load,
  input  logic [TC_W-1:0] tc_load_val,
  output logic [TC_W-1:0] tc_count,
  output logic            drq,
  output logic            done,
  output logic            overrun,
  output logic            underrun,
  input  logic            dev_wr_valid,
  output logic            dev_wr_ready,
  input  logic [7:0]      dev_wr_data,
  output logic            dev_rd_valid,
  input  logic            dev_rd_ready,
  output logic [7:0]      dev_rd_data,
  output logic            cmd_rd_valid,
  input  logic            cmd_rd_ready,
  output logic [7:0]      cmd_rd_data
);
  localparam int unsigned DCW = $clog2(DATA_DEPTH + 1);
  localparam int unsigned CCW = $clog2(CMD_DEPTH + 1);
  localparam logic [DCW-1:0] D_FULL = DCW'(DATA_DEPTH);
  localparam logic [CCW-1:0] C_FULL = CCW'(CMD_DEPTH);

  // byte sequencer state
  logic            phase2, lat_write;
  pdma_pkg::byte_t lat_lo, hold_hi, cur_byte;
  logic acc_fire, byte_act, cur_write, last_byte, wr_b, rd_b;

  // fifo and counter wiring
  logic [DCW-1:0] d_cnt, d_cnt_next;
  logic [CCW-1:0] c_cnt, c_cnt_next;
  pdma_pkg::byte_t d_pop_data, d_push_data;
  logic d_push, d_pop, c_push, push_any;
  logic d_full, d_empty, c_full, c_empty;
  logic tc_zero, tc_next_zero;
  logic ovf_now, unf_now, stop_wr, stop_rd;

  assign acc_ready = !phase2 && !rsp_valid;
  assign acc_fire  = acc_valid && acc_ready;
  assign byte_act  = acc_fire || phase2;
  assign cur_write = phase2 ? lat_write : acc_write;
  assign cur_byte  = phase2 ? lat_lo : (acc_wide ? acc_wdata[15:8] : acc_wdata[7:0]);
  assign last_byte = phase2 || (acc_fire && !acc_wide);
  assign wr_b      = byte_act && cur_write;
  assign rd_b      = byte_act && !cur_write;

  assign d_full  = (d_cnt == D_FULL);
  assign d_empty = (d_cnt == '0);
  assign c_full  = (c_cnt == C_FULL);
  assign c_empty = (c_cnt == '0);

  // device streams pause whenever the host moves a byte
  assign dev_wr_ready = !d_full && !byte_act;
  assign dev_rd_valid = !d_empty && !byte_act;
  assign dev_rd_data  = d_pop_data;
  assign cmd_rd_valid = !c_empty;

  assign push_any    = wr_b && !tc_zero;
  assign d_push      = (push_any && !cmd_phase) || (dev_wr_valid && dev_wr_ready);
  assign d_push_data = push_any ? cur_byte : dev_wr_data;
  assign c_push      = push_any && cmd_phase;
  assign d_pop       = rd_b || (dev_rd_valid && dev_rd_ready);

  assign ovf_now = push_any && (cmd_phase ? c_full : d_full);
  assign unf_now = rd_b && d_empty;
  assign stop_wr = wr_b && last_byte &&
                   (tc_next_zero || (cmd_phase ? (c_cnt_next == C_FULL)
                                               : (d_cnt_next == D_FULL)));
  assign stop_rd = rd_b && last_byte && (d_cnt_next == '0);

  pdma_byte_fifo #(.DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(d_push), .push_data(d_push_data),
    .pop(d_pop), .pop_data(d_pop_data),
    .count(d_cnt), .count_next(d_cnt_next)
  );

  pdma_byte_fifo #(.DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(c_push), .push_data(cur_byte),
    .pop(cmd_rd_ready), .pop_data(cmd_rd_data),
    .count(c_cnt), .count_next(c_cnt_next)
  );

  pdma_tc_counter #(.W(TC_W)) u_tc (
    .clk(clk), .rst_n(rst_n),
    .load(tc_load), .load_val(tc_load_val),
    .dec_req(wr_b), .count(tc_count),
    .zero(tc_zero), .next_zero(tc_next_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase2    <= 1'b0;
      lat_write <= 1'b0;
      lat_lo    <= '0;
      hold_hi   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      drq       <= 1'b0;
      done      <= 1'b0;
      overrun   <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      phase2 <= acc_fire && acc_wide;
      if (acc_fire) begin
        lat_write <= acc_write;
        lat_lo    <= acc_wdata[7:0];
      end
      if (rd_b && !last_byte) hold_hi <= d_pop_data;
      if (rd_b && last_byte) begin
        rsp_valid <= 1'b1;
        rsp_data  <= phase2 ? {hold_hi, d_pop_data} : {8'h00, d_pop_data};
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (tc_load) drq <= 1'b1;
      else if (stop_wr || stop_rd) drq <= 1'b0;
      done     <= stop_wr || stop_rd;
      overrun  <= ovf_now;
      underrun <= unf_now;
    end
  end

  // R2
  wide_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_wide) |=> !acc_ready);
  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R8
  load_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load |=> drq);
endmodule

// File: tb/pdma_port_bench.sv
module pdma_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_wide = 0;
  logic [15:0] acc_wdata = '0;
  logic rsp_ready = 1'b1;
  logic cmd_phase = 0, tc_load = 0;
  logic [23:0] tc_load_val = '0;
  logic dev_wr_valid = 0, dev_rd_ready = 0, cmd_rd_ready = 0;
  logic [7:0] dev_wr_data = '0;
  logic acc_ready, rsp_valid, drq, done, overrun, underrun;
  logic dev_wr_ready, dev_rd_valid, cmd_rd_valid;
  logic [15:0] rsp_data;
  logic [23:0] tc_count;
  logic [7:0] dev_rd_data, cmd_rd_data;

  int checks = 0, failures = 0;
  int n_done = 0, n_ovf = 0, n_unf = 0;

  always #2 clk = ~clk;

  pdma_port u_pdma_port (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cmd_phase(cmd_phase), .tc_load(tc_load), .tc_load_val(tc_load_val),
    .tc_count(tc_count), .drq(drq), .done(done), .overrun(overrun),
    .underrun(underrun),
    .dev_wr_valid(dev_wr_valid), .dev_wr_ready(dev_wr_ready), .dev_wr_data(dev_wr_data),
    .dev_rd_valid(dev_rd_valid), .dev_rd_ready(dev_rd_ready), .dev_rd_data(dev_rd_data),
    .cmd_rd_valid(cmd_rd_valid), .cmd_rd_ready(cmd_rd_ready), .cmd_rd_data(cmd_rd_data)
  );

  always @(negedge clk) if (rst_n) begin
    if (done) n_done++;
    if (overrun) n_ovf++;
    if (underrun) n_unf++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_tc(input int v);
    @(negedge clk); tc_load = 1; tc_load_val = 24'(v);
    @(negedge clk); tc_load = 0;
  endtask

  task automatic host_wr(input bit wide, input logic [15:0] d);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_wide = wide; acc_wdata = d;
    @(negedge clk); acc_valid = 0;
    if (wide) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic host_rd(input bit wide, output logic [15:0] r);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_wide = wide;
    @(negedge clk); acc_valid = 0;
    if (wide) @(negedge clk);
    r = rsp_data;
    @(negedge clk);
  endtask

  task automatic dev_fill(input logic [7:0] d);
    @(negedge clk); dev_wr_valid = 1; dev_wr_data = d;
    @(negedge clk); dev_wr_valid = 0;
  endtask

  task automatic dev_take(output logic [7:0] b, output bit got);
    @(negedge clk); got = dev_rd_valid; b = dev_rd_data; dev_rd_ready = got;
    @(negedge clk); dev_rd_ready = 0;
  endtask

  task automatic cmd_take(output logic [7:0] b, output bit got);
    @(negedge clk); got = cmd_rd_valid; b = cmd_rd_data; cmd_rd_ready = got;
    @(negedge clk); cmd_rd_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] b, exp_b [0:63];
    logic [15:0] r;
    bit got;
    int d0, o0, u0, ne;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!drq && !rsp_valid && !done && !overrun && !underrun, "R1 flags", drq, 0);
    chk(tc_count == 0 && acc_ready, "R1 count/ready", tc_count, 0);
    chk(!dev_rd_valid && !cmd_rd_valid && dev_wr_ready, "R1 fifos", dev_rd_valid, 0);

    // R2/R4/R8/R11: wide writes, high byte first
    load_tc(100);
    chk(drq == 1 && tc_count == 100, "R8 load", tc_count, 100);
    for (int i = 0; i < 6; i++) begin
      host_wr(1, {8'(i*37+5), 8'(i*11+200)});
      exp_b[2*i] = 8'(i*37+5); exp_b[2*i+1] = 8'(i*11+200);
    end
    chk(tc_count == 88, "R4 wide count", tc_count, 88);
    chk(drq == 1, "R9 drq held", drq, 1);
    for (int i = 0; i < 12; i++) begin
      dev_take(b, got);
      chk(got && b == exp_b[i], "R2 byte order", b, exp_b[i]);
    end
    // narrow writes use low byte only
    for (int i = 0; i < 4; i++) host_wr(0, {8'hEE, 8'(i*3+1)});
    for (int i = 0; i < 4; i++) begin
      dev_take(b, got);
      chk(got && b == 8'(i*3+1), "R2 narrow", b, i*3+1);
    end
    dev_take(b, got);
    chk(!got, "R11 empty after drain", got, 0);

    // R6/R9: fill to 16, drq drop at full, then overrun
    load_tc(1000);
    d0 = n_done;
    for (int i = 0; i < 16; i++) begin
      host_wr(0, 16'(i + 8'h40));
      if (i < 15) chk(drq == 1, "R9 drq before full", drq, 1);
    end
    chk(drq == 0 && n_done == d0 + 1, "R9 full stop", n_done - d0, 1);
    chk(!dev_wr_ready, "R11 wr_ready full", dev_wr_ready, 0);
    o0 = n_ovf;
    host_wr(1, 16'hDEAD);
    chk(n_ovf == o0 + 2, "R6 overrun pulses", n_ovf - o0, 2);
    chk(tc_count == 1000 - 18, "R4 count on overrun", tc_count, 1000 - 18);
    for (int i = 0; i < 16; i++) begin
      dev_take(b, got);
      chk(got && b == 8'(i + 8'h40), "R6 contents kept", b, i + 8'h40);
    end

    // R4/R9 sweep: counter reaching zero stops drq
    for (int n = 1; n <= 6; n++) begin
      load_tc(n);
      d0 = n_done;
      for (int i = 0; i < n; i++) begin
        host_wr(0, 16'(n*16 + i));
        chk(tc_count == 24'(n - i - 1), "R4 sweep count", tc_count, n - i - 1);
        chk(drq == (i < n - 1), "R9 sweep drq", drq, (i < n - 1));
      end
      chk(n_done == d0 + 1, "R9 sweep done", n_done - d0, 1);
      o0 = n_ovf;
      host_wr(0, 16'h00FF);
      chk(tc_count == 0 && n_ovf == o0, "R4 zero drop", tc_count, 0);
      for (int i = 0; i < n; i++) begin
        dev_take(b, got);
        chk(got && b == 8'(n*16 + i), "R4 sweep data", b, n*16 + i);
      end
      dev_take(b, got);
      chk(!got, "R4 dropped byte absent", got, 0);
    end

    // R5: command phase steering, 32-byte capacity
    cmd_phase = 1;
    load_tc(40);
    host_wr(1, 16'h1234);
    host_wr(0, 16'h0056);
    chk(!dev_rd_valid, "R5 data untouched", dev_rd_valid, 0);
    cmd_take(b, got); chk(got && b == 8'h12, "R5 cmd hi", b, 8'h12);
    cmd_take(b, got); chk(got && b == 8'h34, "R5 cmd lo", b, 8'h34);
    cmd_take(b, got); chk(got && b == 8'h56, "R5 cmd narrow", b, 8'h56);
    load_tc(40);
    d0 = n_done;
    for (int i = 0; i < 32; i++) host_wr(0, 16'(i ^ 8'h5A));
    chk(drq == 0 && n_done == d0 + 1, "R9 cmd full stop", drq, 0);
    o0 = n_ovf;
    host_wr(0, 16'h0077);
    chk(n_ovf == o0 + 1, "R6 cmd overrun", n_ovf - o0, 1);
    for (int i = 0; i < 32; i++) begin
      cmd_take(b, got);
      chk(got && b == 8'(i ^ 8'h5A), "R6 cmd contents", b, i ^ 8'h5A);
    end
    chk(!cmd_rd_valid && !dev_rd_valid, "R5 both empty", cmd_rd_valid, 0);
    cmd_phase = 0;

    // R3/R10 sweep: device fills n bytes, host reads wide pairs
    for (int n = 1; n <= 16; n++) begin
      for (int i = 0; i < n; i++) dev_fill(8'(n*7 + i*13));
      load_tc(5);
      d0 = n_done; u0 = n_unf;
      ne = 0;
      while (ne < n) begin
        host_rd(1, r);
        chk(r[15:8] == 8'(n*7 + ne*13), "R3 read hi", r[15:8], 8'(n*7 + ne*13));
        if (ne + 1 < n)
          chk(r[7:0] == 8'(n*7 + (ne+1)*13), "R3 read lo", r[7:0], 8'(n*7 + (ne+1)*13));
        else
          chk(r[7:0] == 8'h00, "R7 short read zero", r[7:0], 0);
        ne += 2;
        chk(drq == (ne < n), "R10 drq", drq, (ne < n));
      end
      chk(n_done == d0 + 1, "R10 done once", n_done - d0, 1);
      chk(n_unf == u0 + (n % 2), "R7 underrun count", n_unf - u0, n % 2);
    end

    // R3 narrow read and R7 empty read
    dev_fill(8'hC3);
    host_rd(0, r);
    chk(r == 16'h00C3, "R3 narrow read", r, 16'h00C3);
    u0 = n_unf;
    host_rd(1, r);
    chk(r == 16'h0000 && n_unf == u0 + 2, "R7 empty read", r, 0);
    dev_fill(8'h99);
    dev_take(b, got);
    chk(got && b == 8'h99, "R7 state unchanged", b, 8'h99);

    // R3 response hold under back-pressure
    dev_fill(8'hAB);
    rsp_ready = 0;
    @(negedge clk); acc_valid = 1; acc_write = 0; acc_wide = 0;
    @(negedge clk); acc_valid = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_data == 16'h00AB && !acc_ready, "R3 hold", rsp_data, 16'h00AB);
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid && acc_ready, "R3 release", rsp_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule